// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

This block is one bank of general-purpose pins, from two to eight of them, behind a 32-bit register port. Every pin carries a 4-bit function code that turns it into an input, a driven output or an interrupt source. One register drives the output pins. Reading that same register returns the present level of every pin.

Pins set up as interrupt sources pass their synchronised input level to a detector. The detector's trigger code selects low level, high level, falling edge, rising edge or both edges. A qualifying event sets a sticky pending bit. Software clears pending bits by writing ones to them. A per-pin mask decides which pending bits reach the single combined interrupt line.

Register offsets, in bytes: function select 0x00, data 0x04 (function select plus four), trigger 0x08, mask 0x0C, pending 0x10. A read has no side effect, and the read data follows the address in the same cycle. A write is accepted on the rising clock edge while `regEn` and `regWe` are both high.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every function field, the data, trigger and pending registers, `padOe` and `irqOut` read 0, and every mask bit reads 1.
- R2: Bits [4n+3:4n] of the function register belong to pin n. Code 0x1 makes the pin an output: `padOe[n]` is 1 and `padOut[n]` equals data bit n. Code 0xF makes the pin an interrupt source. Code 0x0, and every other code, makes it an undriven input, with `padOe[n]` and `padOut[n]` at 0.
- R3: Bit n of the data register (offset 0x04) holds the drive value of pin n. A read returns that bit for output pins and the synchronised pad level for all other pins. A pad change shows in the read one edge later than the edge that follows it, which is the second rising edge after the change.
- R4: Bits [4n+2:4n] of the trigger register (offset 0x08) hold pin n's code. Bit 4n+3 is not stored and always reads 0. Code 0 detects a low level and code 1 a high level.
- R5: Code 2 detects a falling edge, code 3 a rising edge and code 4 either edge. Codes 5 to 7 never raise an event. For every mode, the pending bit is set on the third rising edge after the pad change.
- R6: `irqOut` is 1 exactly when some pending bit is set whose mask bit (offset 0x0C, bit n) is 0.
- R7: A pending bit (offset 0x10, bit n) is set only while pin n's function is 0xF. It is set whatever its mask bit says.
- R8: Writing the pending register clears every bit written as 1 and leaves the bits written as 0. In a level mode, if the level is still present, the bit reads set again right after the clear.
- R9: When a clear and a new event for the same pin fall in the same cycle, the pending bit stays set.
- R10: Register bits above the pin count read 0 and ignore writes. Unmapped addresses read 0, and a write to them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regEn | input | 1 | Register access enable |
| regWe | input | 1 | Write when high, read when low |
| regAddr | input | ADDR_W | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from the address |
| padIn | input | PIN_COUNT | Pad input levels, asynchronous |
| padOut | output | PIN_COUNT | Pad drive values |
| padOe | output | PIN_COUNT | Pad output enables |
| irqOut | output | 1 | Combined interrupt, high while any unmasked pending bit is set |

## Verification
The hardest case to reach from the ports is a pending-bit clear that lands in the same cycle as a fresh event on that same pin. The pad change must be placed exactly two edges before the clear write, so that it has passed through both synchroniser stages when the write edge arrives. The stimulus counts the synchroniser stages edge by edge: it raises the pad, waits two falling edges and then drives the clear write. The read that follows shows whether the new event won over the clear. The bench also runs a level-mode clear while the level is still held, and an edge-mode clear with no new event, so that both outcomes of the clear are seen.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_DATA = 3'd2,
    SEL_TRIG = 3'd3,
    SEL_MASK = 3'd4,
    SEL_PEND = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   cfgWr;
    logic   dataWr;
    logic   trigWr;
    logic   maskWr;
    logic   pendClr;
    rdSel_e rdSel;
  } ctrlStrb_t;

  localparam logic [3:0] FN_IN  = 4'h0;
  localparam logic [3:0] FN_OUT = 4'h1;
  localparam logic [3:0] FN_IRQ = 4'hF;

  localparam logic [2:0] TRG_LOW  = 3'd0;
  localparam logic [2:0] TRG_HIGH = 3'd1;
  localparam logic [2:0] TRG_FALL = 3'd2;
  localparam logic [2:0] TRG_RISE = 3'd3;
  localparam logic [2:0] TRG_BOTH = 3'd4;

  localparam int OFS_CFG  = 'h00;
  localparam int OFS_DATA = OFS_CFG + 'h4;
  localparam int OFS_TRIG = 'h08;
  localparam int OFS_MASK = 'h0C;
  localparam int OFS_PEND = 'h10;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrb_t         strb
);

  rdSel_e hitSel;
  logic   wrGo;

  always_comb begin
    case (regAddr)
      ADDR_W'(OFS_CFG):  hitSel = SEL_CFG;
      ADDR_W'(OFS_DATA): hitSel = SEL_DATA;
      ADDR_W'(OFS_TRIG): hitSel = SEL_TRIG;
      ADDR_W'(OFS_MASK): hitSel = SEL_MASK;
      ADDR_W'(OFS_PEND): hitSel = SEL_PEND;
      default:           hitSel = SEL_NONE;
    endcase
  end

  assign wrGo = regEn & regWe;

  always_comb begin
    strb         = '0;
    strb.rdSel   = regEn ? hitSel : SEL_NONE;
    strb.cfgWr   = wrGo && (hitSel == SEL_CFG);
    strb.dataWr  = wrGo && (hitSel == SEL_DATA);
    strb.trigWr  = wrGo && (hitSel == SEL_TRIG);
    strb.maskWr  = wrGo && (hitSel == SEL_MASK);
    strb.pendClr = wrGo && (hitSel == SEL_PEND);
  end

  // R10: a write reaches at most one register
  a_r10_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cfgWr, strb.dataWr, strb.trigWr, strb.maskWr, strb.pendClr}));

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqOut
);

  localparam int CFG_W = 4 * PIN_COUNT;

  logic [CFG_W-1:0]          cfgQ;
  logic [PIN_COUNT-1:0]      dataQ, maskQ, pendQ;
  logic [PIN_COUNT-1:0][2:0] trigQ;
  logic [PIN_COUNT-1:0]      syncA, syncB, prevQ;
  logic [PIN_COUNT-1:0]      isOut, isIrq, evt, clrMask, pendD, levelVec;
  logic [CFG_W-1:0]          trigWide;

  // two-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      dataQ <= '0;
      trigQ <= '0;
      maskQ <= '1;
      pendQ <= '0;
    end else begin
      if (strb.cfgWr)  cfgQ  <= wdata[CFG_W-1:0];
      if (strb.dataWr) dataQ <= wdata[PIN_COUNT-1:0];
      if (strb.trigWr) begin
        for (int k = 0; k < PIN_COUNT; k++) trigQ[k] <= wdata[4*k +: 3];
      end
      if (strb.maskWr) maskQ <= wdata[PIN_COUNT-1:0];
      pendQ <= pendD;
    end
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic hit;

    assign isOut[i] = (cfgQ[4*i +: 4] == FN_OUT);
    assign isIrq[i] = (cfgQ[4*i +: 4] == FN_IRQ);

    always_comb begin
      case (trigQ[i])
        TRG_LOW:  hit = !syncB[i];
        TRG_HIGH: hit = syncB[i];
        TRG_FALL: hit = prevQ[i] & !syncB[i];
        TRG_RISE: hit = !prevQ[i] & syncB[i];
        TRG_BOTH: hit = prevQ[i] ^ syncB[i];
        default:  hit = 1'b0;
      endcase
    end

    assign evt[i]             = isIrq[i] & hit;
    assign trigWide[4*i +: 4] = {1'b0, trigQ[i]};

    // R8: a pending bit stays set until it is cleared
    a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rstN)
      pendQ[i] && !clrMask[i] |=> pendQ[i]);

    // R8: a clear with no new event drops the bit
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
      clrMask[i] && !evt[i] |=> !pendQ[i]);

    // R9: an event in the clearing cycle wins
    a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
      clrMask[i] && evt[i] |=> pendQ[i]);

    // R7: a pending bit only rises for an interrupt-source pin
    a_r7_pend_needs_irq_fn: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendQ[i]) |-> $past(cfgQ[4*i +: 4]) == FN_IRQ);
  end

  assign clrMask  = strb.pendClr ? wdata[PIN_COUNT-1:0] : '0;
  assign pendD    = (pendQ & ~clrMask) | evt;
  assign padOe    = isOut;
  assign padOut   = dataQ & isOut;
  assign levelVec = (dataQ & isOut) | (syncB & ~isOut);
  assign irqOut   = |(pendQ & ~maskQ);

  always_comb begin
    rdata = '0;
    case (strb.rdSel)
      SEL_CFG:  rdata[CFG_W-1:0]     = cfgQ;
      SEL_DATA: rdata[PIN_COUNT-1:0] = levelVec;
      SEL_TRIG: rdata[CFG_W-1:0]     = trigWide;
      SEL_MASK: rdata[PIN_COUNT-1:0] = maskQ;
      SEL_PEND: rdata[PIN_COUNT-1:0] = pendQ;
      default:  rdata                = '0;
    endcase
  end

  // R6: with every pin masked the interrupt line stays low
  a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regEn,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqOut
);

  ctrlStrb_t strb;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regEn   (regEn),
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_bank_dp #(.PIN_COUNT(PIN_COUNT), .DATA_W(32)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .irqOut (irqOut)
  );

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PIN_COUNT  = 8;
  localparam int ADDR_W     = 5;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 regEn = 1'b0;
  logic                 regWe = 1'b0;
  logic [ADDR_W-1:0]    regAddr = '0;
  logic [31:0]          regWdata = '0;
  logic [31:0]          regRdata;
  logic [PIN_COUNT-1:0] padIn = '0;
  logic [PIN_COUNT-1:0] padOut;
  logic [PIN_COUNT-1:0] padOe;
  logic                 irqOut;

  int chkCnt = 0;
  int errCnt = 0;
  bit doneFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    chkCnt++;
    if (got !== exp) begin
      errCnt++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regEn = 1'b0; regWe = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    regEn = 1'b1; regWe = 1'b0; regAddr = a;
    #1;
    d = regRdata;
    regEn = 1'b0;
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    busRead(5'h00, v); check("R1 cfg", v, 32'h0);
    busRead(5'h04, v); check("R1 data", v, 32'h0);
    busRead(5'h08, v); check("R1 trig", v, 32'h0);
    busRead(5'h0C, v); check("R1 mask", v, 32'h0000_00FF);
    busRead(5'h10, v); check("R1 pend", v, 32'h0);
    check("R1 padOe", 32'(padOe), 32'h0);
    check("R1 irqOut", 32'(irqOut), 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] v;
    busWrite(5'h00, 32'h0000_1051);   // pin0 out, pin1 code 5, pin3 out
    busWrite(5'h04, 32'h0000_00FF);
    check("R2 padOe", 32'(padOe), 32'h09);
    check("R2 padOut", 32'(padOut), 32'h09);
    busRead(5'h04, v); check("R3 out readback", v, 32'h09);
    busWrite(5'h04, 32'h0000_0001);
    check("R2 padOut follows data", 32'(padOut), 32'h01);
    busWrite(5'h00, 32'h0);
    busWrite(5'h04, 32'h0);
  endtask

  task automatic t_inputSync();
    logic [31:0] v;
    padIn = 8'hA5;
    waitNeg(1);
    busRead(5'h04, v); check("R3 sync not yet", v, 32'h0);
    waitNeg(1);
    busRead(5'h04, v); check("R3 sync level", v, 32'hA5);
    padIn = 8'h00;
    waitNeg(3);
  endtask

  task automatic t_level();
    logic [31:0] v;
    padIn = 8'h04;
    waitNeg(3);
    busWrite(5'h08, 32'h0010_0000);   // pin2 low, pin5 high
    busWrite(5'h00, 32'h00F0_0F00);   // pins 2 and 5 interrupt sources
    busRead(5'h10, v); check("R4 idle levels no pend", v, 32'h0);
    padIn = 8'h00;
    waitNeg(3);
    busRead(5'h10, v); check("R4 low level pend", v, 32'h04);
    check("R7 masked irq low", 32'(irqOut), 32'h0);
    busWrite(5'h0C, 32'h0000_00FB);
    check("R6 unmasked irq", 32'(irqOut), 32'h1);
    busWrite(5'h10, 32'h0000_0004);
    busRead(5'h10, v); check("R8 level re-sets", v, 32'h04);
    padIn = 8'h24;                    // pin2 high, pin5 high
    waitNeg(3);
    busRead(5'h10, v); check("R4 high level pend pin5", v, 32'h24);
    busWrite(5'h10, 32'h0000_0004);
    busRead(5'h10, v); check("R8 clear only written bit", v, 32'h20);
    check("R6 masked pin5 keeps irq low", 32'(irqOut), 32'h0);
    busWrite(5'h00, 32'h0);
    busWrite(5'h10, 32'hFF);
    busWrite(5'h0C, 32'hFF);
    padIn = 8'h00;
    waitNeg(3);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    busWrite(5'h08, 32'hFFFF_FFFF);
    busRead(5'h08, v); check("R4 trig field width", v, 32'h7777_7777);
    busWrite(5'h08, 32'h0003_5432);   // p0 fall, p1 rise, p2 both, p3 code5, p4 rise
    busWrite(5'h00, 32'h0000_FFFF);   // pins 0..3 interrupt sources, pin4 input
    busWrite(5'h10, 32'hFF);
    padIn = 8'h1F;
    waitNeg(2);
    busRead(5'h10, v); check("R5 latency not yet", v, 32'h0);
    waitNeg(1);
    busRead(5'h10, v); check("R5 R7 rise edges", v, 32'h06);
    busWrite(5'h10, 32'hFF);
    busRead(5'h10, v); check("R8 edge clear", v, 32'h0);
    padIn = 8'h00;
    waitNeg(3);
    busRead(5'h10, v); check("R5 fall edges", v, 32'h05);
  endtask

  task automatic t_sameCycle();
    logic [31:0] v;
    padIn = 8'h02;
    waitNeg(3);
    busRead(5'h10, v); check("R9 setup pend", v, 32'h07);
    padIn = 8'h00;
    waitNeg(3);
    busWrite(5'h10, 32'h05);          // keep only pin1 pending
    busRead(5'h10, v); check("R9 before", v, 32'h02);
    padIn = 8'h02;                    // rising edge on pin1
    waitNeg(2);
    regEn = 1'b1; regWe = 1'b1; regAddr = 5'h10; regWdata = 32'h02;
    @(negedge clk);
    regEn = 1'b0; regWe = 1'b0;
    busRead(5'h10, v); check("R9 event beats clear", v, 32'h02);
    busWrite(5'h10, 32'h02);
    busRead(5'h10, v); check("R9 later clear", v, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    busWrite(5'h0C, 32'hFFFF_FF00);
    busRead(5'h0C, v); check("R10 mask upper bits", v, 32'h0);
    busWrite(5'h14, 32'hFFFF_FFFF);
    busRead(5'h0C, v); check("R10 unmapped write ignored", v, 32'h0);
    busRead(5'h04, v); check("R10 data upper bits", v & 32'hFFFF_FF00, 32'h0);
    busRead(5'h14, v); check("R10 unmapped read", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!doneFlag) begin
      errCnt++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
      $finish;
    end
  end

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);
    t_reset();
    t_output();
    t_inputSync();
    t_level();
    t_edges();
    t_sameCycle();
    t_unused();
    doneFlag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
    $finish;
  end

endmodule